// File: doc/BRIEF.md
# ECC Read-Modify-Write Sequencer

This block sits between a host write port and a memory command port in front of a memory whose words carry a SECDED code. When a host write covers only some bytes of a code word, the block does not send it straight to memory. It reads the stored word, checks and corrects it, merges in the new bytes, re-encodes the word and writes the whole word back. A scrub request goes through the same sequence for one address. In that case no host bytes are merged, so only the corrected stored word is written back.

A write that covers every byte skips the read. It leaves as a single write with freshly computed check bits. With protection switched off, writes pass through with their byte enables, and scrub requests are acknowledged without touching memory. Only one sequence is in flight at a time. The host is accepted at the start of a sequence and is held off until the sequence ends.

Top module: `rmw_seq`

## Requirements
- R1: With `ecc_en` high, a write whose `host_be` is not all ones is accepted in the idle state and starts a sequence. The first memory command is a read (`mem_cmd_write`=0) of that address. `host_ready` stays low from the cycle after acceptance until the sequence is over. The write-back carries the stored bytes where `host_be` is 0 and the host bytes where it is 1, with `mem_cmd_be` all ones.
- R2: With `ecc_en` high, a command with `host_scrub` high runs the same sequence with every byte enable treated as 0. The write-back carries the corrected stored word.
- R3: No write is issued while a read of the sequence is outstanding. The write-back command appears exactly two cycles after the cycle in which `mem_rd_valid` returns clean or correctable data: one cycle to load the merge buffer and one cycle on which merge-ready is seen.
- R4: A single flipped bit anywhere in the 39-bit stored code word is corrected before merging. It raises no flag.
- R5: A double-bit error in the returned word cancels the write-back. `ecc_uncorr` goes high for exactly one cycle, the cycle after `mem_rd_valid`.
- R6: With `ecc_en` high, a write with all byte enables set is issued in the idle state as one write. It is presented combinationally while `host_valid` is high, and `host_ready` equals `mem_cmd_ready`. It has `mem_cmd_be` all ones, the computed check bits, and no read.
- R7: With `ecc_en` low, writes pass through in the idle state with `host_be` forwarded and `mem_cmd_check` zero. A scrub is accepted at once and issues no memory command.
- R8: Check bits: data bit i sits at the i-th code position, counting from 1, that is not a power of two. `check[5:0]` is the XOR of the positions of all set data bits. `check[6]` is the even parity over the 32 data bits and `check[5:0]`.
- R9: A synchronous reset returns the sequencer to idle, drops any sequence in flight and clears the merge buffer. After reset no command is issued until the host sends one.
- R10: A read or write-back command of a sequence holds its valid, direction and address until `mem_cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ecc_en | input | 1 | Enables protection and read-modify-write handling |
| host_valid | input | 1 | Host command valid |
| host_ready | output | 1 | Host command accepted in this cycle |
| host_addr | input | ADDR_W | Target word address |
| host_wdata | input | DATA_W | Write data |
| host_be | input | DATA_W/8 | Byte enables of the write |
| host_scrub | input | 1 | Command is a scrub of one address |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 for write, 0 for read |
| mem_cmd_addr | output | ADDR_W | Memory word address |
| mem_cmd_wdata | output | DATA_W | Write data to memory |
| mem_cmd_be | output | DATA_W/8 | Byte enables to memory |
| mem_cmd_check | output | 7 | Check bits written with the data |
| mem_rd_valid | input | 1 | Read data return valid |
| mem_rd_data | input | DATA_W | Returned data |
| mem_rd_check | input | 7 | Returned check bits |
| ecc_uncorr | output | 1 | One-cycle pulse on an uncorrectable read |

## Verification
The bench builds the block with a 4-bit address and the default 32-bit data word. The 16 words then fit in a bench-held memory, and every write can be checked against the expected merged word and code. Because the bench owns that memory, it can flip single data bits, single check bits and bit pairs before a sequence, which exercises correction, silent repair by scrubbing, and the cancelled write-back. A stalling ready pattern and a reset while a read is outstanding exercise command holding and the restart from idle.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ISSUE_RD = 3'd1,
        ST_WAIT_RD  = 3'd2,
        ST_MERGE    = 3'd3,
        ST_ISSUE_WR = 3'd4,
        ST_DONE     = 3'd5
    } seq_state_e;

    // Smallest number of Hamming parity bits covering dw data bits
    function automatic int hamming_par_bits(input int dw);
        int res;
        res = 0;
        for (int k = 15; k >= 1; k--) begin
            if ((1 << k) >= dw + k + 1) res = k;
        end
        return res;
    endfunction

    // Code position (1-based) of data bit idx, skipping powers of two
    function automatic int data_pos(input int idx);
        int pos;
        pos = idx + 1;
        for (int k = 0; k < 16; k++) begin
            if ((1 << k) <= pos) pos = pos + 1;
        end
        return pos;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import rmw_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int CHK_W  = hamming_par_bits(DATA_W) + 1,
    localparam int PAR_W  = CHK_W - 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);

    logic [PAR_W-1:0] syn;

    always_comb begin
        syn = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_i[i]) syn = syn ^ PAR_W'(data_pos(i));
        end
        check_o = {^{data_i, syn}, syn};
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import rmw_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int CHK_W  = hamming_par_bits(DATA_W) + 1,
    localparam int PAR_W  = CHK_W - 1,
    localparam int CODE_N = DATA_W + PAR_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  check_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);

    logic [CHK_W-1:0] recalc;
    logic [PAR_W-1:0] syn;
    logic             odd;
    logic             beyond;

    secded_enc #(.DATA_W(DATA_W)) u_recalc (
        .data_i (data_i),
        .check_o(recalc)
    );

    always_comb begin
        syn    = recalc[PAR_W-1:0] ^ check_i[PAR_W-1:0];
        // parity of the whole received word: data parity from the recalculated code
        odd    = recalc[PAR_W] ^ (^recalc[PAR_W-1:0]) ^ (^check_i);
        beyond = int'(syn) > CODE_N;
        data_o = data_i;
        for (int i = 0; i < DATA_W; i++) begin
            if (odd && (syn == PAR_W'(data_pos(i)))) data_o[i] = ~data_i[i];
        end
        single_o = odd && !beyond;
        double_o = (!odd && (syn != '0)) || (odd && beyond);
    end

endmodule

// File: rtl/merge_buf.sv
module merge_buf #(
    parameter  int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              release_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [BE_W-1:0]   be_i,
    output logic [DATA_W-1:0] word_o,
    output logic              ready_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              ready;
    } mb_t;

    mb_t               mb_d, mb_q;
    logic [DATA_W-1:0] merged;

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign merged[b*8 +: 8] = be_i[b] ? new_i[b*8 +: 8] : base_i[b*8 +: 8];
    end

    always_comb begin
        mb_d = mb_q;
        if (load_i) begin
            mb_d.word  = merged;
            mb_d.ready = 1'b1;
        end else if (release_i) begin
            mb_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mb_q <= '0;
        else     mb_q <= mb_d;
    end

    assign word_o  = mb_q.word;
    assign ready_o = mb_q.ready;

    // R3
    ready_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> ready_o);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ready_o && (word_o == '0)));

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter  int ADDR_W = 16,
    parameter  int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int CHK_W  = hamming_par_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [BE_W-1:0]   host_be,
    input  logic              host_scrub,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic              mem_cmd_write,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [DATA_W-1:0] mem_cmd_wdata,
    output logic [BE_W-1:0]   mem_cmd_be,
    output logic [CHK_W-1:0]  mem_cmd_check,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [CHK_W-1:0]  mem_rd_check,
    output logic              ecc_uncorr
);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              uncorr;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              full_be, go_rmw, go_direct;
    logic              merge_load, merge_release, merge_ready;
    logic [DATA_W-1:0] merge_word;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single, dec_double;
    logic [DATA_W-1:0] enc_in;
    logic [CHK_W-1:0]  enc_chk;
    logic              use_chk;

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .data_i  (mem_rd_data),
        .check_i (mem_rd_check),
        .data_o  (dec_data),
        .single_o(dec_single),
        .double_o(dec_double)
    );

    merge_buf #(.DATA_W(DATA_W)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .load_i   (merge_load),
        .release_i(merge_release),
        .base_i   (dec_data),
        .new_i    (seq_q.wdata),
        .be_i     (seq_q.be),
        .word_o   (merge_word),
        .ready_o  (merge_ready)
    );

    // one encoder, shared by the direct path and the write-back
    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_in),
        .check_o(enc_chk)
    );

    always_comb begin
        full_be   = &host_be;
        go_rmw    = ecc_en && (host_scrub || !full_be);
        go_direct = !host_scrub && (!ecc_en || full_be);

        seq_d        = seq_q;
        seq_d.uncorr = 1'b0;

        merge_load    = 1'b0;
        merge_release = 1'b0;
        host_ready    = 1'b0;
        mem_cmd_valid = 1'b0;
        mem_cmd_write = 1'b0;
        mem_cmd_addr  = seq_q.addr;
        mem_cmd_wdata = '0;
        mem_cmd_be    = '0;
        enc_in        = merge_word;
        use_chk       = 1'b0;

        unique case (seq_q.state)
            ST_IDLE: begin
                host_ready    = go_direct ? mem_cmd_ready : 1'b1;
                mem_cmd_valid = host_valid && go_direct;
                mem_cmd_write = 1'b1;
                mem_cmd_addr  = host_addr;
                mem_cmd_wdata = host_wdata;
                mem_cmd_be    = ecc_en ? {BE_W{1'b1}} : host_be;
                enc_in        = host_wdata;
                use_chk       = ecc_en;
                if (host_valid && go_rmw) begin
                    seq_d.state = ST_ISSUE_RD;
                    seq_d.addr  = host_addr;
                    seq_d.wdata = host_wdata;
                    seq_d.be    = host_scrub ? '0 : host_be;
                end
            end
            ST_ISSUE_RD: begin
                mem_cmd_valid = 1'b1;
                if (mem_cmd_ready) seq_d.state = ST_WAIT_RD;
            end
            ST_WAIT_RD: begin
                if (mem_rd_valid) begin
                    if (dec_double) begin
                        seq_d.uncorr = 1'b1;
                        seq_d.state  = ST_DONE;
                    end else begin
                        merge_load  = 1'b1;
                        seq_d.state = ST_MERGE;
                    end
                end
            end
            ST_MERGE: begin
                if (merge_ready) seq_d.state = ST_ISSUE_WR;
            end
            ST_ISSUE_WR: begin
                mem_cmd_valid = 1'b1;
                mem_cmd_write = 1'b1;
                mem_cmd_wdata = merge_word;
                mem_cmd_be    = {BE_W{1'b1}};
                use_chk       = 1'b1;
                if (mem_cmd_ready) begin
                    merge_release = 1'b1;
                    seq_d.state   = ST_DONE;
                end
            end
            ST_DONE: begin
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    assign mem_cmd_check = use_chk ? enc_chk : '0;
    assign ecc_uncorr    = seq_q.uncorr;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state  <= ST_IDLE;
            seq_q.addr   <= '0;
            seq_q.wdata  <= '0;
            seq_q.be     <= '0;
            seq_q.uncorr <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R1
    busy_holds_host_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state != ST_IDLE) |-> !host_ready);

    // R3
    no_wr_before_data_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == ST_ISSUE_RD || seq_q.state == ST_WAIT_RD)
            |-> !(mem_cmd_valid && mem_cmd_write));

    // R3
    wr_needs_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_write && seq_q.state != ST_IDLE) |-> merge_ready);

    // R4
    dec_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !(dec_single && dec_double));

    // R5
    uncorr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ecc_uncorr |=> !ecc_uncorr);

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !mem_cmd_ready && seq_q.state != ST_IDLE)
            |=> (mem_cmd_valid && $stable(mem_cmd_write) && $stable(mem_cmd_addr)));

endmodule

// File: tb/rmw_seq_test.sv
`timescale 1ns/1ps
module rmw_seq_test;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int CW = 7;
    localparam int PW = 6;
    localparam int NC = 38;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ecc_en = 1'b1;
    logic          host_valid = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [BW-1:0] host_be = '0;
    logic          host_scrub = 1'b0;
    logic          mem_cmd_ready = 1'b0;
    logic          mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic [CW-1:0] mem_rd_check = '0;
    logic          host_ready, mem_cmd_valid, mem_cmd_write, ecc_uncorr;
    logic [AW-1:0] mem_cmd_addr;
    logic [DW-1:0] mem_cmd_wdata;
    logic [BW-1:0] mem_cmd_be;
    logic [CW-1:0] mem_cmd_check;

    rmw_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .ecc_en(ecc_en),
        .host_valid(host_valid), .host_ready(host_ready), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be), .host_scrub(host_scrub),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_wdata(mem_cmd_wdata), .mem_cmd_be(mem_cmd_be),
        .mem_cmd_check(mem_cmd_check), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_rd_check(mem_rd_check),
        .ecc_uncorr(ecc_uncorr)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference code: parity bit k covers code positions with bit k set (R8)
    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [NC:1]   code;
        logic [PW-1:0] p;
        int j;
        code = '0;
        j = 0;
        for (int q = 1; q <= NC; q++) begin
            if ((q & (q - 1)) != 0) begin
                code[q] = d[j];
                j++;
            end
        end
        for (int k = 0; k < PW; k++) begin
            p[k] = 1'b0;
            for (int q = 1; q <= NC; q++) if (((q >> k) & 1) == 1) p[k] = p[k] ^ code[q];
        end
        return {(^d) ^ (^p), p};
    endfunction

    function automatic void ref_dec(input logic [DW-1:0] d, input logic [CW-1:0] c,
                                    output logic [DW-1:0] fixed, output logic dbl);
        logic [CW-1:0] r;
        logic [PW-1:0] syn;
        logic          par;
        int j;
        r = ref_enc(d);
        syn = r[PW-1:0] ^ c[PW-1:0];
        par = (^d) ^ (^c);
        fixed = d;
        dbl = 1'b0;
        if (par && int'(syn) <= NC) begin
            j = 0;
            for (int q = 1; q <= NC; q++) begin
                if ((q & (q - 1)) != 0) begin
                    if (q == int'(syn)) fixed[j] = ~fixed[j];
                    j++;
                end
            end
        end else if (syn != '0 || par) begin
            dbl = 1'b1;
        end
    endfunction

    logic [DW-1:0] mem_d [16];
    logic [CW-1:0] mem_c [16];

    // reference model state: 0 idle, 1 read cmd, 2 await data, 3 merge, 4 write cmd, 5 done
    int            ph = 0;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data, m_merged;
    logic [BW-1:0] m_be;
    logic          unc_e = 1'b0;
    int            unc_seen = 0;
    bit            pend = 0;
    int            cnt = 0;
    logic [AW-1:0] rd_a;
    int            cyc = 0;

    logic          s_hready, s_cv, s_w;
    logic [AW-1:0] s_a;
    logic [DW-1:0] s_wd;
    logic [BW-1:0] s_be;

    // sample and compare away from the active edge
    always @(negedge clk) begin
        bit            dir, e_valid, e_write, e_ready;
        logic [AW-1:0] e_addr;
        logic [DW-1:0] e_wd;
        logic [BW-1:0] e_be;
        logic [CW-1:0] e_ck;
        string         tg;
        s_hready = host_ready;
        s_cv = mem_cmd_valid;
        s_w = mem_cmd_write;
        s_a = mem_cmd_addr;
        s_wd = mem_cmd_wdata;
        s_be = mem_cmd_be;
        if (!rst) begin
            if (ecc_uncorr) unc_seen++;
            dir = !host_scrub && (!ecc_en || host_be == 4'hF);
            e_ready = (ph == 0) && (dir ? mem_cmd_ready : 1'b1);
            e_valid = (ph == 0) ? (host_valid && dir) : (ph == 1 || ph == 4);
            e_write = (ph != 1);
            e_addr = (ph == 0) ? host_addr : m_addr;
            e_wd = (ph == 0) ? host_wdata : m_merged;
            e_be = (ph == 0 && !ecc_en) ? host_be : 4'hF;
            e_ck = (ph == 0 && !ecc_en) ? '0 : ref_enc(e_wd);
            tg = (ph == 0) ? (ecc_en ? "R6" : "R7") : ((ph == 2 || ph == 3) ? "R3" : "R1");
            chk(host_ready == e_ready, {tg, " host_ready"}, 64'(host_ready), 64'(e_ready));
            chk(mem_cmd_valid == e_valid, {tg, " cmd_valid"}, 64'(mem_cmd_valid), 64'(e_valid));
            chk(ecc_uncorr == unc_e, "R5 uncorr", 64'(ecc_uncorr), 64'(unc_e));
            if (e_valid) begin
                chk(mem_cmd_write == e_write, {tg, " write"}, 64'(mem_cmd_write), 64'(e_write));
                chk(mem_cmd_addr == e_addr, {tg, " addr"}, 64'(mem_cmd_addr), 64'(e_addr));
                if (e_write) begin
                    chk(mem_cmd_wdata == e_wd, {tg, " wdata"}, 64'(mem_cmd_wdata), 64'(e_wd));
                    chk(mem_cmd_be == e_be, {tg, " be"}, 64'(mem_cmd_be), 64'(e_be));
                    chk(mem_cmd_check == e_ck, "R8 check bits", 64'(mem_cmd_check), 64'(e_ck));
                end
            end
        end
    end

    // reference model and memory model, updated on the edge from sampled values
    always @(posedge clk) begin
        logic [DW-1:0] fx;
        logic          dbl;
        cyc++;
        if (rst) begin
            ph = 0;
            unc_e = 1'b0;
            pend = 0;
        end else begin
            unc_e = 1'b0;
            if (s_cv && mem_cmd_ready) begin
                if (s_w) begin
                    for (int b = 0; b < BW; b++) if (s_be[b]) mem_d[s_a][b*8 +: 8] = s_wd[b*8 +: 8];
                    if (s_be == 4'hF) mem_c[s_a] = mem_cmd_check;
                end else begin
                    pend = 1;
                    cnt = 2;
                    rd_a = s_a;
                end
            end else if (pend && cnt > 0) begin
                cnt--;
            end
            case (ph)
                0: if (host_valid && s_hready && ecc_en && (host_scrub || host_be != 4'hF)) begin
                    m_addr = host_addr;
                    m_data = host_wdata;
                    m_be = host_scrub ? 4'h0 : host_be;
                    ph = 1;
                end
                1: if (mem_cmd_ready) ph = 2;
                2: if (mem_rd_valid) begin
                    ref_dec(mem_rd_data, mem_rd_check, fx, dbl);
                    if (dbl) begin
                        ph = 5;
                        unc_e = 1'b1;
                    end else begin
                        for (int b = 0; b < BW; b++)
                            m_merged[b*8 +: 8] = m_be[b] ? m_data[b*8 +: 8] : fx[b*8 +: 8];
                        ph = 3;
                    end
                end
                3: ph = 4;
                4: if (mem_cmd_ready) ph = 5;
                default: ph = 0;
            endcase
        end
        #1;
        mem_cmd_ready = (cyc % 5) != 3;
        if (pend && cnt == 0) begin
            mem_rd_valid = 1'b1;
            mem_rd_data = mem_d[rd_a];
            mem_rd_check = mem_c[rd_a];
            pend = 0;
        end else begin
            mem_rd_valid = 1'b0;
        end
    end

    task automatic do_cmd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [BW-1:0] be, input logic scrub);
        @(posedge clk); #1;
        host_valid = 1'b1;
        host_addr = a;
        host_wdata = d;
        host_be = be;
        host_scrub = scrub;
        do @(negedge clk); while (!host_ready);
        @(posedge clk); #1;
        host_valid = 1'b0;
        host_scrub = 1'b0;
        while (ph != 0) begin @(posedge clk); #1; end
        repeat (2) @(posedge clk);
    endtask

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [BW-1:0] be);
        logic [DW-1:0] r;
        for (int b = 0; b < BW; b++) r[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
        return r;
    endfunction

    task automatic chk_word(input int a, input logic [DW-1:0] exp, input string tag);
        chk(mem_d[a] == exp, {tag, " stored data"}, 64'(mem_d[a]), 64'(exp));
        chk(mem_c[a] == ref_enc(exp), {tag, " stored code"}, 64'(mem_c[a]), 64'(ref_enc(exp)));
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        logic [DW-1:0] orig;
        for (int a = 0; a < 16; a++) begin
            mem_d[a] = 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101);
            mem_c[a] = ref_enc(mem_d[a]);
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: idle after reset
        chk(host_ready == 1'b1, "R9 ready after reset", 64'(host_ready), 64'd1);
        chk(mem_cmd_valid == 1'b0, "R9 no command after reset", 64'(mem_cmd_valid), 64'd0);
        chk(ecc_uncorr == 1'b0, "R9 no flag after reset", 64'(ecc_uncorr), 64'd0);

        // R6: full write goes out directly with its code
        do_cmd(4'd1, 32'hDEAD_BEEF, 4'hF, 1'b0);
        chk_word(1, 32'hDEAD_BEEF, "R6");

        // R1: partial writes merged with stored bytes
        orig = mem_d[2];
        do_cmd(4'd2, 32'h1122_3344, 4'b0101, 1'b0);
        chk_word(2, mrg(orig, 32'h1122_3344, 4'b0101), "R1");
        orig = mem_d[3];
        do_cmd(4'd3, 32'hCAFE_F00D, 4'b0010, 1'b0);
        chk_word(3, mrg(orig, 32'hCAFE_F00D, 4'b0010), "R1");

        // R2/R4: scrub repairs a flipped data bit
        orig = mem_d[4];
        @(posedge clk); #1 mem_d[4][7] = ~mem_d[4][7];
        do_cmd(4'd4, 32'hFFFF_FFFF, 4'hF, 1'b1);
        chk_word(4, orig, "R2 R4");

        // R4: scrub repairs a flipped check bit
        orig = mem_d[5];
        @(posedge clk); #1 mem_c[5][2] = ~mem_c[5][2];
        do_cmd(4'd5, 32'h0, 4'h0, 1'b1);
        chk_word(5, orig, "R4");

        // R4: partial write over a stored word with a data error
        orig = mem_d[6];
        @(posedge clk); #1 mem_d[6][30] = ~mem_d[6][30];
        do_cmd(4'd6, 32'hA1B2_C3D4, 4'b1000, 1'b0);
        chk_word(6, mrg(orig, 32'hA1B2_C3D4, 4'b1000), "R4");
        chk(unc_seen == 0, "R4 no flag on single error", 64'(unc_seen), 64'd0);

        // R5: double error cancels the write-back
        @(posedge clk); #1 mem_d[7][0] = ~mem_d[7][0]; mem_d[7][1] = ~mem_d[7][1];
        orig = mem_d[7];
        do_cmd(4'd7, 32'h5555_5555, 4'b0011, 1'b0);
        chk(mem_d[7] == orig, "R5 word untouched", 64'(mem_d[7]), 64'(orig));
        chk(unc_seen == 1, "R5 one flag cycle", 64'(unc_seen), 64'd1);

        // R7: protection off
        @(posedge clk); #1 ecc_en = 1'b0;
        orig = mem_d[8];
        do_cmd(4'd8, 32'h9988_7766, 4'b0011, 1'b0);
        chk(mem_d[8] == mrg(orig, 32'h9988_7766, 4'b0011), "R7 bytes forwarded",
            64'(mem_d[8]), 64'(mrg(orig, 32'h9988_7766, 4'b0011)));
        orig = mem_d[9];
        do_cmd(4'd9, 32'h0, 4'h0, 1'b1);
        chk(mem_d[9] == orig, "R7 scrub without access", 64'(mem_d[9]), 64'(orig));
        @(posedge clk); #1 ecc_en = 1'b1;

        // R10/R6: back-to-back full writes under stalls
        for (int i = 0; i < 6; i++) begin
            do_cmd(4'(11 + (i % 3)), 32'h0F0F_0000 + 32'(i), 4'hF, 1'b0);
            chk_word(11 + (i % 3), 32'h0F0F_0000 + 32'(i), "R10");
        end

        // R9: reset while a read is outstanding
        orig = mem_d[10];
        @(posedge clk); #1;
        host_valid = 1'b1; host_addr = 4'd10; host_wdata = 32'h7777_7777; host_be = 4'b0100;
        do @(negedge clk); while (!host_ready);
        @(posedge clk); #1 host_valid = 1'b0;
        while (ph != 2) begin @(posedge clk); #1; end
        rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(mem_cmd_valid == 1'b0, "R9 idle after mid reset", 64'(mem_cmd_valid), 64'd0);
        chk(mem_d[10] == orig, "R9 no write after reset", 64'(mem_d[10]), 64'(orig));
        do_cmd(4'd10, 32'h1234_5678, 4'b0001, 1'b0);
        chk_word(10, mrg(orig, 32'h1234_5678, 4'b0001), "R9");

        // R8: code of a single-bit data word
        do_cmd(4'd14, 32'h0000_0001, 4'hF, 1'b0);
        chk(mem_c[14] == 7'b100_0011, "R8 code of bit 0", 64'(mem_c[14]), 64'h43);

        repeat (5) @(posedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            report();
        end
    end

endmodule